// File: doc/BRIEF.md
# Reset Cause Status and Request Register

This block holds a single 32-bit word that tells software why the system last came out of reset and lets software ask for a new reset. The five top bits of the word carry meaning and everything below them reads as zero. Three of the five are cause flags that software acknowledges by writing a one to them. The other two are request flags that software sets by writing a one. Setting either request flag also raises a one-cycle system reset request on the output.

A small saturating counter of reset events decides whether the next system reset is reported as a power-on. The counter is zero only after true power-up or after a soft power-on request. While it is zero, the next system reset loads the word with only the power-on flag set. Any later reset leaves the word as it is. Button event inputs set their own cause flags. The word can be read or written only through an 8-byte window, and within that window only at addresses where bit 2 is one.

Top module: `reset_cause_ctrl`

## Requirements
- R1: After the synchronous power-up reset `rst_i`, the register reads 0x00000000 and `sys_rst_req_o` is low.
- R2: The register responds only when `bus_addr_i[15:3]` equals 0xF020 >> 3 and `bus_addr_i[2]` is 1. Every other read returns zero, every other write has no effect, and reads without `bus_valid_i` return zero.
- R3: A register write with a one in bit 31 (power-on), bit 28 (button power-on) or bit 27 (button external) clears that bit. A zero in those bits leaves them unchanged.
- R4: A register write with a one in bit 30 (soft power-on) or bit 29 (soft external) sets that bit. Bits 26:0 always read zero, and writes to them are ignored.
- R5: A register write with bit 30 set zeroes the reset-event counter and drives `sys_rst_req_o` high for exactly the following cycle.
- R6: A register write with bit 29 set and bit 30 clear drives `sys_rst_req_o` high for the following cycle and leaves the counter unchanged, so the next system reset does not alter the register.
- R7: On `sys_rst_i`, if the counter is zero the register becomes exactly 0x80000000. Otherwise the register keeps its value. Either way the counter increments.
- R8: The counter saturates at its maximum value, so no number of system resets makes a later reset report power-on.
- R9: A high `key_por_i` sets bit 28 and a high `key_xir_i` sets bit 27 in the next cycle. These sets take precedence over a clearing write in the same cycle.
- R10: When `sys_rst_i` is high, a register write or key event in the same cycle is dropped and `sys_rst_req_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-up reset |
| sys_rst_i | input | 1 | One cycle per system reset event |
| key_por_i | input | 1 | Button power-on event |
| key_xir_i | input | 1 | Button external reset event |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A counter stuck at zero would make the very next system reset rewrite the word to the bare power-on value. A counter that wrapped would do the same after many resets. A read following that reset exposes either fault. A wrong request flag update shows up at the first read, and a wrong request pulse shows up in the cycle after the write. The bench therefore compares the read-back word and the request output against a behavioural model after every clock, and it runs long reset chains to expose saturation faults.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int unsigned DATA_W = 32;

    localparam logic [DATA_W-1:0] IMPL_MASK = 32'hF800_0000;
    localparam logic [DATA_W-1:0] W1C_MASK  = 32'h9800_0000;
    localparam logic [DATA_W-1:0] W1S_MASK  = 32'h6000_0000;
    localparam logic [DATA_W-1:0] POR_WORD  = 32'h8000_0000;

    typedef struct packed {
        logic        pwr_on;
        logic        sw_pwr_on;
        logic        sw_ext;
        logic        key_pwr_on;
        logic        key_ext;
        logic [26:0] unused;
    } cause_t;

    typedef struct packed {
        logic              hit;
        logic [DATA_W-1:0] data;
    } wr_op_t;

    function automatic cause_t merge_write(cause_t cur, logic [DATA_W-1:0] wdata);
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] r;
        v = wdata & IMPL_MASK;
        r = cur;
        r = r & ~(v & W1C_MASK);
        r = r | (v & W1S_MASK);
        return cause_t'(r);
    endfunction

endpackage

// File: rtl/rcc_decode.sv
module rcc_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rd_hit_o,
    output logic              wr_hit_o
);
    logic in_window;

    always_comb begin
        in_window = (addr_i[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && addr_i[2];
        rd_hit_o  = valid_i && !write_i && in_window;
        wr_hit_o  = valid_i && write_i && in_window;
    end
endmodule

// File: rtl/rcc_epoch.sv
module rcc_epoch #(
    parameter int unsigned CNT_W = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sys_rst_i,
    input  logic rearm_i,
    output logic armed_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (sys_rst_i) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (rearm_i) begin
            cnt_q <= '0;
        end
    end

    assign armed_o = (cnt_q == '0);
endmodule

// File: rtl/rcc_status.sv
module rcc_status
    import rcc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sys_rst_i,
    input  logic              armed_i,
    input  wr_op_t            wr_i,
    input  logic              key_por_i,
    input  logic              key_xir_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              req_o,
    output logic              rearm_o
);
    cause_t stat_q, stat_d;
    logic   req_d;
    logic [DATA_W-1:0] wmask;

    always_comb begin
        wmask   = wr_i.data & IMPL_MASK;
        stat_d  = stat_q;
        req_d   = 1'b0;
        rearm_o = 1'b0;
        if (sys_rst_i) begin
            if (armed_i) begin
                stat_d = cause_t'(POR_WORD);
            end
        end else begin
            if (wr_i.hit) begin
                stat_d  = merge_write(stat_q, wr_i.data);
                rearm_o = wmask[30];
                req_d   = wmask[30] | wmask[29];
            end
            if (key_por_i) begin
                stat_d.key_pwr_on = 1'b1;
            end
            if (key_xir_i) begin
                stat_d.key_ext = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
            req_o  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            req_o  <= req_d;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hF020,
    parameter int unsigned CNT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sys_rst_i,
    input  logic              key_por_i,
    input  logic              key_xir_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              sys_rst_req_o
);
    logic              rd_hit, wr_hit;
    logic              armed, rearm;
    logic [DATA_W-1:0] stat;
    wr_op_t            wr_op;

    rcc_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .valid_i  (bus_valid_i),
        .write_i  (bus_write_i),
        .addr_i   (bus_addr_i),
        .rd_hit_o (rd_hit),
        .wr_hit_o (wr_hit)
    );

    assign wr_op.hit  = wr_hit;
    assign wr_op.data = bus_wdata_i;

    rcc_epoch #(.CNT_W(CNT_W)) u_epoch (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sys_rst_i (sys_rst_i),
        .rearm_i   (rearm),
        .armed_o   (armed)
    );

    rcc_status u_status (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sys_rst_i (sys_rst_i),
        .armed_i   (armed),
        .wr_i      (wr_op),
        .key_por_i (key_por_i),
        .key_xir_i (key_xir_i),
        .stat_o    (stat),
        .req_o     (sys_rst_req_o),
        .rearm_o   (rearm)
    );

    assign bus_rdata_o = rd_hit ? stat : '0;
endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              sys_rst_i,
    input logic              wr_hit,
    input logic [31:0]       wdata,
    input logic              armed,
    input logic [31:0]       stat,
    input logic              req,
    input logic [31:0]       rdata,
    input logic [ADDR_W-1:0] addr
);
    assert_por_load_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sys_rst_i && armed) |=> (stat == 32'h8000_0000));

    assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (sys_rst_i && !armed) |=> !armed);

    assert_soft_por_req_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_hit && wdata[30] && !sys_rst_i) |=> req);

    assert_soft_xir_req_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_hit && wdata[29] && !sys_rst_i) |=> req);

    assert_sys_rst_wins_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        sys_rst_i |=> !req);

    assert_low_bits_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        stat[26:0] == 27'd0);

    assert_window_only_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdata != 32'd0) |-> addr[2]);
endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sys_rst_i (sys_rst_i),
    .wr_hit    (wr_hit),
    .wdata     (bus_wdata_i),
    .armed     (armed),
    .stat      (stat),
    .req       (sys_rst_req_o),
    .rdata     (bus_rdata_o),
    .addr      (bus_addr_i)
);

// File: tb/tb_reset_cause_ctrl.sv
module tb_reset_cause_ctrl;
    localparam logic [15:0] REG_A = 16'hF024;
    localparam int CNT_MAX = 15;

    logic        clk = 1'b0;
    logic        rst_i, sys_rst_i, key_por_i, key_xir_i;
    logic        bus_valid_i, bus_write_i;
    logic [15:0] bus_addr_i;
    logic [31:0] bus_wdata_i, bus_rdata_o;
    logic        sys_rst_req_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [31:0] m_stat;
    int          m_cnt;
    logic        m_req;

    always #10 clk = ~clk;

    reset_cause_ctrl dut (
        .clk_i(clk), .rst_i(rst_i), .sys_rst_i(sys_rst_i),
        .key_por_i(key_por_i), .key_xir_i(key_xir_i),
        .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .sys_rst_req_o(sys_rst_req_o)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
                summary();
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic hit(logic [15:0] a);
        return (a[15:3] == REG_A[15:3]) && a[2];
    endfunction

    // reads the register at the window address, without a clock edge
    task automatic peek(string tag);
        bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = REG_A;
        #1;
        check(tag, bus_rdata_o, m_stat);
        bus_valid_i = 1'b0;
    endtask

    // one clock with the given stimulus, then model update and comparison
    task automatic step(string tag, logic sr, logic we, logic [15:0] a,
                        logic [31:0] d, logic kp, logic kx);
        logic [31:0] v;
        sys_rst_i = sr; key_por_i = kp; key_xir_i = kx;
        bus_valid_i = we; bus_write_i = we; bus_addr_i = a; bus_wdata_i = d;
        @(posedge clk);
        m_req = 1'b0;
        if (sr) begin
            if (m_cnt == 0) m_stat = 32'h8000_0000;
            if (m_cnt < CNT_MAX) m_cnt++;
        end else begin
            if (we && hit(a)) begin
                v = d & 32'hF800_0000;
                m_stat = m_stat & ~(v & 32'h9800_0000);
                m_stat = m_stat | (v & 32'h6000_0000);
                if (v[30]) begin m_cnt = 0; m_req = 1'b1; end
                else if (v[29]) m_req = 1'b1;
            end
            if (kp) m_stat[28] = 1'b1;
            if (kx) m_stat[27] = 1'b1;
        end
        @(negedge clk);
        sys_rst_i = 1'b0; key_por_i = 1'b0; key_xir_i = 1'b0;
        bus_valid_i = 1'b0; bus_write_i = 1'b0;
        check({tag, " req"}, {31'd0, sys_rst_req_o}, {31'd0, m_req});
        peek({tag, " reg"});
    endtask

    task automatic wr(string tag, logic [15:0] a, logic [31:0] d);
        step(tag, 1'b0, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic sysrst(string tag);
        step(tag, 1'b1, 1'b0, REG_A, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 1'b0, REG_A, 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        logic [31:0] lf;
        rst_i = 1'b1; sys_rst_i = 1'b0; key_por_i = 1'b0; key_xir_i = 1'b0;
        bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
        m_stat = '0; m_cnt = 0; m_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_i = 1'b0;
        // R1 reset state
        check("R1 req after reset", {31'd0, sys_rst_req_o}, 32'd0);
        peek("R1 reg after reset");
        // R7 first system reset reports power-on
        sysrst("R7 first sys reset");
        check("R7 power-on word", m_stat, 32'h8000_0000);
        // R3 write-one-clear
        wr("R3 clear zero no-op", REG_A, 32'h0000_0000);
        wr("R3 clear bit31", REG_A, 32'h8000_0000);
        // R4 write-one-set plus R5 request
        wr("R4 R5 set 30/29", REG_A, 32'h6000_0000);
        idle("R5 pulse one cycle");
        wr("R4 low bits ignored", REG_A, 32'h07FF_FFFF);
        // R5 rearm: next sys reset loads POR word
        sysrst("R5 rearmed sys reset");
        // R6 soft external: counter untouched
        wr("R6 soft ext", REG_A, 32'h2000_0000);
        sysrst("R6 no power-on after soft ext");
        // R9 button events and clearing
        step("R9 key por", 1'b0, 1'b0, REG_A, 32'd0, 1'b1, 1'b0);
        step("R9 key xir", 1'b0, 1'b0, REG_A, 32'd0, 1'b0, 1'b1);
        wr("R3 clear keys", REG_A, 32'h1800_0000);
        step("R9 set beats clear", 1'b0, 1'b1, REG_A, 32'h1800_0000, 1'b1, 1'b1);
        // R2 decode
        wr("R2 bit2 clear write", 16'hF020, 32'hF800_0000);
        wr("R2 other window write", 16'hF02C, 32'hF800_0000);
        wr("R2 low address write", 16'h0024, 32'hF800_0000);
        bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = 16'hF020; #1;
        check("R2 read bit2 clear", bus_rdata_o, 32'd0);
        bus_addr_i = 16'hF02C; #1;
        check("R2 read outside", bus_rdata_o, 32'd0);
        bus_valid_i = 1'b0; bus_addr_i = REG_A; #1;
        check("R2 read without valid", bus_rdata_o, 32'd0);
        // R10 sys reset beats write and keys
        step("R10 sys reset with write", 1'b1, 1'b1, REG_A, 32'h7800_0000, 1'b1, 1'b0);
        // R8 saturation
        wr("R8 clear all", REG_A, 32'h9800_0000);
        for (int i = 0; i < 40; i++) sysrst("R8 sys reset chain");
        check("R8 no power-on after chain", m_stat[31], 1'b0);
        // mixed patterns compared every cycle
        lf = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step("R3 R4 R5 R6 R7 R9 mixed", lf[3:0] == 4'd0, lf[4],
                 lf[5] ? REG_A : {lf[31:20], 1'b0, lf[6], 2'b00},
                 {lf[11:7], 27'd0} | (lf[12] ? 32'h0000_0F0F : 32'd0),
                 lf[13] & lf[14], lf[15] & lf[16]);
        end
        summary();
    end
endmodule